// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block sits between a set of device request lines and a processor. Eight maskable device sources and one software trap source are captured in pending latches. A per-source enable register gates which device lines can latch, and the processor can hold a global mask level to keep the maskable request line quiet during critical code. The controller picks the most urgent pending source and drives a handler vector, so the processor never has to poll the devices to find the cause.

A separate non-maskable input is latched on its own. It raises its own request line regardless of the mask and takes over the vector output while it is pending. For maskable sources, the controller keeps an in-service stack with one bit per source. Only a source strictly more urgent than the most urgent one in service may interrupt, so nesting follows priority. An end-of-interrupt pulse pops the most urgent in-service entry, which restores the previous threshold.

All outputs are registered. A request that is present at a clock edge is reflected on the outputs just after that edge.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After synchronous reset, `irq`, `nmi_req`, `vector` and `in_service` are all zero and every per-source enable is cleared.
- R2: A device line latches into pending only while its enable bit is 1. The enable register is loaded from `en_data` when `en_wr` is high. A disabled line raises nothing. A latched request stays pending after the line drops, until it is acknowledged.
- R3: Source index 0 is the most urgent. While `irq` is high and `nmi_req` is low, `vector` equals VEC_BASE (default 32) plus the index of the chosen source.
- R4: The trap input `trap_set` latches a request for source index 8. It ranks below every device source, needs no enable, and its vector is VEC_BASE+8 (40).
- R5: While `cpu_mask` is 1, `irq` stays low and the pending state is kept. Once the mask is 0, the request reappears.
- R6: The non-maskable input latches and raises `nmi_req` whatever the mask is. While it is pending, `vector` is NMI_VEC (default 2). An `ack` seen while `nmi_req` is high clears it and leaves `in_service` unchanged.
- R7: An `ack` seen while `irq` is high and `nmi_req` is low clears the pending bit of the source shown on `vector` and sets that source's bit in `in_service`.
- R8: A pending source raises `irq` only if its index is lower than that of every set `in_service` bit. Sources of equal or lower priority are held back.
- R9: A more urgent source can preempt and be acknowledged on top of one in service. Each `eoi` pulse clears only the lowest-index set `in_service` bit, which re-admits sources held back by it.
- R10: An `ack` seen while both `irq` and `nmi_req` are low changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dev_req | input | N_SRC | Level device request lines |
| en_wr | input | 1 | Load the enable register |
| en_data | input | N_SRC | New per-source enables |
| cpu_mask | input | 1 | Global mask for the maskable line |
| trap_set | input | 1 | Software trap request pulse |
| nmi_in | input | 1 | Non-maskable event input |
| ack | input | 1 | One-cycle acknowledge from the processor |
| eoi | input | 1 | End-of-interrupt pulse |
| irq | output | 1 | Maskable request to the processor |
| nmi_req | output | 1 | Non-maskable request to the processor |
| vector | output | VEC_W | Handler vector |
| in_service | output | N_SRC+1 | In-service stack, bit per source |

## Verification
The hardest state to reach is a three-deep stack, where a trap or a low-priority device is held pending under two nested in-service entries. After each end-of-interrupt pulse, the correct source must re-emerge while a non-maskable event and the mask toggle around it. Directed sequences first build the nested states with chosen pulse timing, including acknowledge and end-of-interrupt in the same cycle. A long random phase with sparse requests and frequent acknowledges then keeps the stack populated, while a behavioural model checks every cycle.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
  typedef enum logic [1:0] {
    TGT_NONE = 2'd0,
    TGT_NMI  = 2'd1,
    TGT_SRC  = 2'd2
  } ack_tgt_e;
endpackage

// File: rtl/prio_irq_pending.sv
module prio_irq_pending #(
  parameter int N_SRC = 8,
  localparam int NS = N_SRC + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N_SRC-1:0] dev_req,
  input  logic [N_SRC-1:0] en,
  input  logic          trap_set,
  input  logic          nmi_in,
  input  logic [NS-1:0] clr_src,
  input  logic          clr_nmi,
  output logic [NS-1:0] pend_n,
  output logic          nmi_n
);
  logic [NS-1:0] pend_q;
  logic          nmi_q;

  always_comb begin
    pend_n = (pend_q & ~clr_src) | {trap_set, dev_req & en};
    nmi_n  = (nmi_q & ~clr_nmi) | nmi_in;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0;
      nmi_q  <= 1'b0;
    end else begin
      pend_q <= pend_n;
      nmi_q  <= nmi_n;
    end
  end

  for (genvar g = 0; g < NS; g++) begin : g_hold
    // R2: a latched request survives until its own clear
    p_hold_r2: assert property (@(posedge clk) disable iff (rst)
      (pend_q[g] && !clr_src[g]) |=> pend_q[g]);
  end

  // R6: the non-maskable latch drops only on its clear
  p_nmi_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (nmi_q && !clr_nmi) |=> nmi_q);
endmodule

// File: rtl/prio_irq_isr.sv
module prio_irq_isr #(
  parameter int NS = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          eoi,
  input  logic [NS-1:0] set_src,
  output logic [NS-1:0] isr_q,
  output logic [NS-1:0] allow_n
);
  logic [NS-1:0] isr_n;
  logic [NS-1:0] top_bit;

  always_comb begin
    top_bit = isr_q & (~isr_q + NS'(1));
    isr_n   = (eoi ? (isr_q & ~top_bit) : isr_q) | set_src;
  end

  // allow_n[i]: no in-service entry at index <= i
  assign allow_n[0] = ~isr_n[0];
  for (genvar g = 1; g < NS; g++) begin : g_allow
    assign allow_n[g] = allow_n[g-1] & ~isr_n[g];
  end

  always_ff @(posedge clk) begin
    if (rst) isr_q <= '0;
    else     isr_q <= isr_n;
  end

  // R7: at most one source is pushed per cycle
  p_single_push_r7: assert property (@(posedge clk) disable iff (rst)
    $onehot0(set_src));

  // R9: a lone end-of-interrupt pops exactly one entry
  p_pop_one_r9: assert property (@(posedge clk) disable iff (rst)
    (eoi && (isr_q != '0) && (set_src == '0)) |=>
      ($countones(isr_q) + 1 == $countones($past(isr_q))));
endmodule

// File: rtl/prio_irq_resolve.sv
module prio_irq_resolve #(
  parameter int NS    = 9,
  parameter int IDX_W = 4
) (
  input  logic [NS-1:0]    cand,
  output logic             hit,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    hit = |cand;
    idx = '0;
    for (int i = NS - 1; i >= 0; i--) begin
      if (cand[i]) idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import prio_irq_pkg::*;
#(
  parameter int N_SRC    = 8,
  parameter int VEC_W    = 8,
  parameter int VEC_BASE = 32,
  parameter int NMI_VEC  = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_SRC-1:0]   dev_req,
  input  logic               en_wr,
  input  logic [N_SRC-1:0]   en_data,
  input  logic               cpu_mask,
  input  logic               trap_set,
  input  logic               nmi_in,
  input  logic               ack,
  input  logic               eoi,
  output logic               irq,
  output logic               nmi_req,
  output logic [VEC_W-1:0]   vector,
  output logic [N_SRC:0]     in_service
);
  localparam int NS    = N_SRC + 1;
  localparam int IDX_W = $clog2(NS);

  logic [N_SRC-1:0] en_q;
  logic             irq_q, nmi_q;
  logic [IDX_W-1:0] sel_q;
  logic [VEC_W-1:0] vec_q;
  ack_tgt_e         tgt;
  logic [NS-1:0]    clr_src, pend_n, allow_n, isr_q;
  logic             clr_nmi, nmi_n, hit;
  logic [IDX_W-1:0] idx;

  // the acknowledge applies to what the processor was shown
  always_comb begin
    tgt = TGT_NONE;
    if (ack) begin
      if (nmi_q)      tgt = TGT_NMI;
      else if (irq_q) tgt = TGT_SRC;
    end
    clr_nmi = (tgt == TGT_NMI);
    clr_src = (tgt == TGT_SRC) ? (NS'(1) << sel_q) : '0;
  end

  prio_irq_pending #(.N_SRC(N_SRC)) u_pending (
    .clk(clk), .rst(rst), .dev_req(dev_req), .en(en_q),
    .trap_set(trap_set), .nmi_in(nmi_in), .clr_src(clr_src),
    .clr_nmi(clr_nmi), .pend_n(pend_n), .nmi_n(nmi_n)
  );

  prio_irq_isr #(.NS(NS)) u_isr (
    .clk(clk), .rst(rst), .eoi(eoi), .set_src(clr_src),
    .isr_q(isr_q), .allow_n(allow_n)
  );

  prio_irq_resolve #(.NS(NS), .IDX_W(IDX_W)) u_resolve (
    .cand(pend_n & allow_n), .hit(hit), .idx(idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= '0;
      irq_q <= 1'b0;
      nmi_q <= 1'b0;
      sel_q <= '0;
      vec_q <= '0;
    end else begin
      if (en_wr) en_q <= en_data;
      irq_q <= hit & ~cpu_mask;
      nmi_q <= nmi_n;
      sel_q <= idx;
      if (nmi_n)                vec_q <= VEC_W'(NMI_VEC);
      else if (hit & ~cpu_mask) vec_q <= VEC_W'(VEC_BASE + int'(idx));
      else                      vec_q <= '0;
    end
  end

  assign irq        = irq_q;
  assign nmi_req    = nmi_q;
  assign vector     = vec_q;
  assign in_service = isr_q;

  logic [NS-1:0] upto_sel;
  assign upto_sel = (NS'(2) << sel_q) - NS'(1);

  p_mask_quiet_r5: assert property (@(posedge clk) disable iff (rst)
    $past(cpu_mask) |-> !irq_q);
  p_nmi_vector_r6: assert property (@(posedge clk) disable iff (rst)
    nmi_q |-> (vec_q == VEC_W'(NMI_VEC)));
  p_nmi_ack_r6: assert property (@(posedge clk) disable iff (rst)
    (ack && nmi_q) |=> (nmi_q == $past(nmi_in)));
  p_vector_r3: assert property (@(posedge clk) disable iff (rst)
    (irq_q && !nmi_q) |-> (vec_q == VEC_W'(VEC_BASE + int'(sel_q))));
  p_ack_push_r7: assert property (@(posedge clk) disable iff (rst)
    (ack && irq_q && !nmi_q) |=> isr_q[$past(sel_q)]);
  p_threshold_r8: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> ((isr_q & upto_sel) == '0));
  p_idle_ack_r10: assert property (@(posedge clk) disable iff (rst)
    (ack && !irq_q && !nmi_q && !eoi) |=> $stable(isr_q));
endmodule

// File: tb/prio_irq_ctrl_bench.sv
`timescale 1ns/1ps
module prio_irq_ctrl_bench;
  localparam int NB = 9;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] dev_req = '0, en_data = '0;
  logic       en_wr = 0, cpu_mask = 0, trap_set = 0, nmi_in = 0, ack = 0, eoi = 0;
  logic       irq, nmi_req;
  logic [7:0] vector;
  logic [8:0] in_service;

  int checks = 0, errors = 0;
  bit done = 0;

  // reference state
  logic [8:0] m_pend, m_isr;
  logic [7:0] m_en;
  logic       m_nmi, m_irq;
  int         m_sel, m_vec;

  always #4 clk = ~clk;

  prio_irq_ctrl u_prio_irq_ctrl (
    .clk(clk), .rst(rst), .dev_req(dev_req), .en_wr(en_wr), .en_data(en_data),
    .cpu_mask(cpu_mask), .trap_set(trap_set), .nmi_in(nmi_in), .ack(ack),
    .eoi(eoi), .irq(irq), .nmi_req(nmi_req), .vector(vector),
    .in_service(in_service)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model_edge();
    logic [8:0] np, ni;
    logic       nn;
    int thr, best;
    if (rst) begin
      m_pend = '0; m_isr = '0; m_en = '0; m_nmi = 0; m_irq = 0; m_sel = 0; m_vec = 0;
      return;
    end
    np = m_pend; ni = m_isr; nn = m_nmi;
    if (eoi) for (int i = 0; i < NB; i++) if (ni[i]) begin ni[i] = 0; break; end
    if (ack && m_nmi) nn = 0;
    else if (ack && m_irq) begin np[m_sel] = 0; ni[m_sel] = 1; end
    for (int i = 0; i < 8; i++) if (dev_req[i] && m_en[i]) np[i] = 1;
    if (trap_set) np[8] = 1;
    if (nmi_in) nn = 1;
    if (en_wr) m_en = en_data;
    thr = NB;
    for (int i = NB - 1; i >= 0; i--) if (ni[i]) thr = i;
    best = -1;
    for (int i = thr - 1; i >= 0; i--) if (np[i]) best = i;
    m_pend = np; m_isr = ni; m_nmi = nn;
    m_irq = (best >= 0) && !cpu_mask;
    m_sel = (best >= 0) ? best : 0;
    m_vec = nn ? 2 : (m_irq ? 32 + best : 0);
  endtask

  // one clock: model follows the edge, outputs compared at the falling edge
  task automatic step();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    chk("MODEL irq", int'(irq), int'(m_irq));
    chk("MODEL nmi", int'(nmi_req), int'(m_nmi));
    chk("MODEL vector", int'(vector), m_vec);
    chk("MODEL in_service", int'(in_service), int'(m_isr));
    dev_req = '0; en_wr = 0; trap_set = 0; nmi_in = 0; ack = 0; eoi = 0;
  endtask

  task automatic expect_out(string tag, int e_irq, int e_nmi, int e_vec, int e_isr);
    chk({tag, " irq"}, int'(irq), e_irq);
    chk({tag, " nmi"}, int'(nmi_req), e_nmi);
    chk({tag, " vector"}, int'(vector), e_vec);
    chk({tag, " in_service"}, int'(in_service), e_isr);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    step(); step();
    rst = 0;
    step();
    expect_out("R1 reset", 0, 0, 0, 0);

    dev_req = 8'h08; step();
    expect_out("R2 disabled line", 0, 0, 0, 0);
    en_wr = 1; en_data = 8'hFF; step();
    step();
    expect_out("R2 no late latch", 0, 0, 0, 0);
    dev_req = 8'h20; step();
    step();
    expect_out("R2 held after drop", 1, 0, 37, 0);
    dev_req = 8'h04; step();
    expect_out("R3 lower index wins", 1, 0, 34, 0);
    cpu_mask = 1; step();
    expect_out("R5 masked", 0, 0, 0, 0);
    cpu_mask = 0; step();
    expect_out("R5 unmasked", 1, 0, 34, 0);
    ack = 1; step();
    expect_out("R7 ack pushes", 0, 0, 0, 9'h004);
    dev_req = 8'h02; step();
    expect_out("R9 preempt request", 1, 0, 33, 9'h004);
    ack = 1; step();
    expect_out("R9 nested", 0, 0, 0, 9'h006);
    eoi = 1; step();
    expect_out("R9 pop top", 0, 0, 0, 9'h004);
    eoi = 1; step();
    expect_out("R8 threshold restored", 1, 0, 37, 0);
    ack = 1; step();
    eoi = 1; step();
    expect_out("R9 empty", 0, 0, 0, 0);

    trap_set = 1; dev_req = 8'h80; step();
    expect_out("R4 trap below device", 1, 0, 39, 0);
    ack = 1; step();
    expect_out("R8 trap held", 0, 0, 0, 9'h080);
    eoi = 1; step();
    expect_out("R4 trap vector", 1, 0, 40, 0);
    ack = 1; step();
    expect_out("R4 trap in service", 0, 0, 0, 9'h100);
    eoi = 1; step();

    cpu_mask = 1; nmi_in = 1; step();
    expect_out("R6 nmi under mask", 0, 1, 2, 0);
    ack = 1; step();
    expect_out("R6 nmi ack", 0, 0, 0, 0);
    cpu_mask = 0;
    ack = 1; step();
    expect_out("R10 idle ack", 0, 0, 0, 0);

    dev_req = 8'h10; nmi_in = 1; step();
    expect_out("R6 nmi wins", 1, 1, 2, 0);
    ack = 1; step();
    expect_out("R6 device after nmi", 1, 0, 36, 0);
    ack = 1; step();
    dev_req = 8'h10; step();
    expect_out("R8 equal held", 0, 0, 0, 9'h010);
    eoi = 1; step();
    expect_out("R8 equal released", 1, 0, 36, 0);
    ack = 1; eoi = 1; step();
    expect_out("R9 eoi with ack", 0, 0, 0, 9'h010);
    eoi = 1; step();

    for (int n = 0; n < 3000; n++) begin
      dev_req  = ($urandom_range(0, 5) == 0) ? 8'(1 << $urandom_range(0, 7)) : 8'h00;
      trap_set = ($urandom_range(0, 15) == 0);
      nmi_in   = ($urandom_range(0, 63) == 0);
      cpu_mask = ($urandom_range(0, 3) == 0);
      ack      = ($urandom_range(0, 3) == 0);
      eoi      = ($urandom_range(0, 6) == 0);
      en_wr    = ($urandom_range(0, 99) == 0);
      en_data  = 8'($urandom);
      step();
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule